// File: doc/BRIEF.md
# L2 Way-Shrink Power Controller

This block decides how much of a shared second-level cache stays powered across a core's idle periods. It holds the number of enabled cache ways. Each time the package drops into its deepest sleep, the block may turn off a few more ways. Turning off a way means issuing a flush request so the way's data can be written back and the way powered down. The shrink happens in steps, so a machine that goes idle repeatedly walks its cache down to empty. Once the cache is empty, the enhanced deeper-sleep state is allowed.

The block also tracks how long the package stays in the normal running state. When the package wakes from sleep, the block brings the cache back to a minimal two ways. It later restores every way when the workload looks busy again. A busy workload shows up as a high bus-to-core ratio, a long run in the normal state, or the other core asking for a shallow idle state. The cache arrays themselves are outside this block. It only produces the way count, an enable mask, and one-cycle flush and invalidate requests.

Top module: `l2_shrink_ctrl`

## Requirements
- R1: After reset the way count equals NUM_WAYS, every bit of the enable mask is set, and neither the flush request nor the invalidate request is raised.
- R2: A deep-sleep entry strobe removes step_ways_i ways when all of the following hold: the other core reports C4, enhanced sleep is enabled, the residency timer has not expired, and the ratio condition holds. The new count appears one cycle after the strobe, together with a one-cycle flush request.
- R3: The ratio condition holds when bus_ratio_i is below shrink_thresh_i. It also holds when bus_ratio_i is zero, whatever the threshold. A nonzero ratio at or above the threshold prevents the shrink.
- R4: The residency timer counts the cycles spent outside sleep and is cleared on a deep-sleep entry. It expires once the count reaches res_limit_i, and an entry while it is expired does not shrink.
- R5: When shrink_hint_i equals 2'b10, a qualifying entry disables all remaining ways in one step.
- R6: While shrink_block_i is high, an entry disables no ways, and both esleep_ok_o and deep_pd_ok_o are low.
- R7: cache_empty_o is high exactly when the way count is zero. esleep_ok_o additionally requires esleep_en_i high and shrink_block_i low.
- R8: A stop-clock release strobe received while asleep raises the count to two ways when it is below two. This comes with a one-cycle invalidate request. A count of two or more is left unchanged.
- R9: Re-expansion is scheduled by any of three conditions: a nonzero bus_ratio_i above shrink_thresh_i, an expired residency timer, or peer_cstate_i equal to 1, 2 or 3 (C1, C2, C3; 0 is C0 and 4 is C4). The next irq_event_i after that restores all NUM_WAYS ways with a one-cycle invalidate request. A shrink cancels a scheduled re-expansion.
- R10: The count never falls below zero or rises above NUM_WAYS. The enable mask has exactly the lowest way-count bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dsleep_entry_i | input | 1 | Deep-sleep entry strobe |
| peer_c4_i | input | 1 | Other core is in C4 |
| esleep_en_i | input | 1 | Enhanced sleep enable |
| bus_ratio_i | input | RATIO_W | Current bus-to-core ratio, zero means unknown |
| shrink_thresh_i | input | RATIO_W | Ratio threshold for shrinking |
| step_ways_i | input | CNT_W | Ways removed per shrink step |
| shrink_hint_i | input | 2 | 2'b10 requests a full shrink in one step |
| shrink_block_i | input | 1 | Prevents shrinking and the deep states |
| res_limit_i | input | RES_W | Residency timer limit in cycles |
| stpclk_rel_i | input | 1 | Stop-clock release strobe |
| irq_event_i | input | 1 | Interrupt event strobe |
| peer_cstate_i | input | 3 | C-state requested by the other core |
| ways_o | output | CNT_W | Number of enabled ways |
| way_en_o | output | NUM_WAYS | Enable mask, lowest ways first |
| flush_req_o | output | 1 | One-cycle flush-and-disable request |
| invalidate_o | output | 1 | One-cycle invalidate request for re-enabled ways |
| cache_empty_o | output | 1 | No ways enabled |
| esleep_ok_o | output | 1 | Enhanced deeper sleep permitted |
| deep_pd_ok_o | output | 1 | Deepest power-down permitted |

## Verification
A wrong way count is visible at once on ways_o and on way_en_o, one cycle after the strobe that caused it. A wrong sleep flag, residency count or pending re-expansion bit stays hidden until a later strobe. At that strobe the wrong state shows up as a shrink that should have been refused, a restore to two ways that is missing, or an interrupt that fails to refill the cache. For that reason the sequences chain many strobes and compare the count after each one, rather than checking events in isolation.

// File: rtl/l2_shrink_pkg.sv
package l2_shrink_pkg;
  typedef enum logic [2:0] {
    CS_C0 = 3'd0,
    CS_C1 = 3'd1,
    CS_C2 = 3'd2,
    CS_C3 = 3'd3,
    CS_C4 = 3'd4
  } cstate_e;

  localparam logic [1:0] HINT_FULL = 2'b10;

  function automatic logic is_shallow(input logic [2:0] cs);
    return (cs == CS_C1) || (cs == CS_C2) || (cs == CS_C3);
  endfunction
endpackage

// File: rtl/l2_res_timer.sv
module l2_res_timer #(
  parameter int RES_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] limit_i,
  output logic             expired_o
);
  logic [RES_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (run_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/l2_shrink_calc.sv
module l2_shrink_calc #(
  parameter int NUM_WAYS = 8,
  parameter int RATIO_W  = 5,
  localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic               entry_i,
  input  logic               peer_c4_i,
  input  logic               esleep_en_i,
  input  logic               expired_i,
  input  logic               block_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RATIO_W-1:0] thresh_i,
  input  logic [1:0]         hint_i,
  input  logic [CNT_W-1:0]   step_i,
  input  logic [CNT_W-1:0]   ways_i,
  output logic               go_o,
  output logic [CNT_W-1:0]   nxt_o
);
  import l2_shrink_pkg::*;

  logic             ratio_ok;
  logic [CNT_W-1:0] amt;

  always_comb begin
    ratio_ok = (ratio_i == '0) || (ratio_i < thresh_i);
    amt      = (hint_i == HINT_FULL) ? ways_i : step_i;
    nxt_o    = (amt >= ways_i) ? '0 : ways_i - amt;
    go_o     = entry_i && peer_c4_i && esleep_en_i && !expired_i &&
               ratio_ok && !block_i && (ways_i != '0) && (amt != '0);
  end
endmodule

// File: rtl/l2_expand_sched.sv
module l2_expand_sched #(
  parameter int RATIO_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               below_max_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RATIO_W-1:0] thresh_i,
  input  logic               expired_i,
  input  logic [2:0]         peer_cstate_i,
  input  logic               cancel_i,
  input  logic               fire_i,
  output logic               pend_o
);
  import l2_shrink_pkg::*;

  logic trig;

  assign trig = ((ratio_i != '0) && (ratio_i > thresh_i)) || expired_i ||
                is_shallow(peer_cstate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_o <= 1'b0;
    else if (cancel_i || fire_i)  pend_o <= 1'b0;
    else if (trig && below_max_i) pend_o <= 1'b1;
  end
endmodule

// File: rtl/l2_shrink_ctrl.sv
module l2_shrink_ctrl #(
  parameter int NUM_WAYS = 8,
  parameter int RATIO_W  = 5,
  parameter int RES_W    = 16,
  localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dsleep_entry_i,
  input  logic                peer_c4_i,
  input  logic                esleep_en_i,
  input  logic [RATIO_W-1:0]  bus_ratio_i,
  input  logic [RATIO_W-1:0]  shrink_thresh_i,
  input  logic [CNT_W-1:0]    step_ways_i,
  input  logic [1:0]          shrink_hint_i,
  input  logic                shrink_block_i,
  input  logic [RES_W-1:0]    res_limit_i,
  input  logic                stpclk_rel_i,
  input  logic                irq_event_i,
  input  logic [2:0]          peer_cstate_i,
  output logic [CNT_W-1:0]    ways_o,
  output logic [NUM_WAYS-1:0] way_en_o,
  output logic                flush_req_o,
  output logic                invalidate_o,
  output logic                cache_empty_o,
  output logic                esleep_ok_o,
  output logic                deep_pd_ok_o
);
  localparam logic [CNT_W-1:0] MAX_WAYS = CNT_W'(NUM_WAYS);
  localparam logic [CNT_W-1:0] MIN_WAYS = CNT_W'(NUM_WAYS < 2 ? NUM_WAYS : 2);

  logic [CNT_W-1:0] ways_q, nxt;
  logic             asleep_q, expired, go, pend, restore, expand;

  l2_res_timer #(.RES_W(RES_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (!asleep_q),
    .clr_i    (dsleep_entry_i),
    .limit_i  (res_limit_i),
    .expired_o(expired)
  );

  l2_shrink_calc #(.NUM_WAYS(NUM_WAYS), .RATIO_W(RATIO_W)) u_calc (
    .entry_i    (dsleep_entry_i),
    .peer_c4_i  (peer_c4_i),
    .esleep_en_i(esleep_en_i),
    .expired_i  (expired),
    .block_i    (shrink_block_i),
    .ratio_i    (bus_ratio_i),
    .thresh_i   (shrink_thresh_i),
    .hint_i     (shrink_hint_i),
    .step_i     (step_ways_i),
    .ways_i     (ways_q),
    .go_o       (go),
    .nxt_o      (nxt)
  );

  // shrink wins over restore, restore over interrupt expansion
  assign restore = !go && stpclk_rel_i && asleep_q && (ways_q < MIN_WAYS);
  assign expand  = !go && !restore && irq_event_i && pend && (ways_q < MAX_WAYS);

  l2_expand_sched #(.RATIO_W(RATIO_W)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .below_max_i  (ways_q < MAX_WAYS),
    .ratio_i      (bus_ratio_i),
    .thresh_i     (shrink_thresh_i),
    .expired_i    (expired),
    .peer_cstate_i(peer_cstate_i),
    .cancel_i     (go),
    .fire_i       (expand),
    .pend_o       (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ways_q       <= MAX_WAYS;
      asleep_q     <= 1'b0;
      flush_req_o  <= 1'b0;
      invalidate_o <= 1'b0;
    end else begin
      flush_req_o  <= go;
      invalidate_o <= restore || expand;
      if (go)           ways_q <= nxt;
      else if (restore) ways_q <= MIN_WAYS;
      else if (expand)  ways_q <= MAX_WAYS;
      if (dsleep_entry_i)    asleep_q <= 1'b1;
      else if (stpclk_rel_i) asleep_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_en
    assign way_en_o[w] = (CNT_W'(w) < ways_q);
  end

  assign ways_o        = ways_q;
  assign cache_empty_o = (ways_q == '0);
  assign esleep_ok_o   = cache_empty_o && esleep_en_i && !shrink_block_i;
  assign deep_pd_ok_o  = !shrink_block_i;
endmodule

// File: rtl/l2_shrink_ctrl_chk.sv
module l2_shrink_ctrl_chk #(
  parameter int NUM_WAYS = 8,
  localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                dsleep_entry_i,
  input logic                shrink_block_i,
  input logic [CNT_W-1:0]    ways_o,
  input logic [NUM_WAYS-1:0] way_en_o,
  input logic                flush_req_o,
  input logic                invalidate_o,
  input logic                esleep_ok_o,
  input logic                deep_pd_ok_o
);
  a_r2_flush_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> ways_o < $past(ways_o));
  a_r8_inv_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidate_o |-> ways_o > $past(ways_o));
  a_r6_block_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsleep_entry_i && shrink_block_i) |=> !flush_req_o);
  a_r6_block_no_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shrink_block_i |-> (!deep_pd_ok_o && !esleep_ok_o));
  a_r7_esleep_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esleep_ok_o |-> (ways_o == '0));
  a_r10_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ways_o <= CNT_W'(NUM_WAYS));
  a_r10_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(way_en_o) == int'(ways_o));
endmodule

bind l2_shrink_ctrl l2_shrink_ctrl_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/tb_l2_shrink_ctrl.sv
module tb_l2_shrink_ctrl;
  localparam int NUM_WAYS = 8;
  localparam int RATIO_W  = 5;
  localparam int RES_W    = 16;
  localparam int CNT_W    = $clog2(NUM_WAYS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dsleep = 0, peer_c4 = 0, es_en = 1, block = 0, stpclk = 0, irq = 0;
  logic [RATIO_W-1:0] ratio = 0, thresh = 5'd10;
  logic [CNT_W-1:0] step = 2;
  logic [1:0] hint = 0;
  logic [RES_W-1:0] limit = 16'd1000;
  logic [2:0] pcs = 0;
  logic [CNT_W-1:0] ways;
  logic [NUM_WAYS-1:0] way_en;
  logic flush, inv, empty, es_ok, dp_ok;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  l2_shrink_ctrl #(.NUM_WAYS(NUM_WAYS), .RATIO_W(RATIO_W), .RES_W(RES_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dsleep_entry_i(dsleep), .peer_c4_i(peer_c4),
    .esleep_en_i(es_en), .bus_ratio_i(ratio), .shrink_thresh_i(thresh),
    .step_ways_i(step), .shrink_hint_i(hint), .shrink_block_i(block),
    .res_limit_i(limit), .stpclk_rel_i(stpclk), .irq_event_i(irq),
    .peer_cstate_i(pcs), .ways_o(ways), .way_en_o(way_en), .flush_req_o(flush),
    .invalidate_o(inv), .cache_empty_o(empty), .esleep_ok_o(es_ok),
    .deep_pd_ok_o(dp_ok));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // vector: {entry, stpclk, irq, peer_c4, ratio, step, hint, block, pcs, exp_ways, exp_flush, exp_inv}
  typedef struct packed {
    logic ent; logic stp; logic irq; logic pc4;
    logic [4:0] ratio; logic [3:0] step; logic [1:0] hint; logic blk;
    logic [2:0] pcs; logic [3:0] ways; logic fl; logic iv;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1,0,0,1, 6,2,0,0,0, 6,1,0},  // R2 step shrink
    '{1,0,0,1, 6,2,0,0,0, 4,1,0},  // R4 consecutive entries keep shrinking
    '{1,0,0,1,12,2,0,0,0, 4,0,0},  // R3 ratio above threshold
    '{1,0,0,1, 0,2,0,0,0, 2,1,0},  // R3 zero ratio ignored
    '{1,0,0,0, 6,2,0,0,0, 2,0,0},  // R2 peer not in C4
    '{1,0,0,1, 6,2,0,1,0, 2,0,0},  // R6 blocked
    '{1,0,0,1, 6,3,0,0,0, 0,1,0},  // R10 saturate at zero
    '{0,1,0,1, 6,2,0,0,0, 2,0,1},  // R8 restore to two
    '{1,0,0,1, 6,1,2,0,0, 0,1,0},  // R5 full hint
    '{0,1,0,1, 6,2,0,0,0, 2,0,1},  // R8 restore again
    '{0,0,1,1, 6,2,0,0,0, 2,0,0},  // R9 irq without pending
    '{0,0,0,1, 6,2,0,0,2, 2,0,0},  // R9 peer C2 schedules
    '{0,0,1,1, 6,2,0,0,0, 8,0,1},  // R9 irq expands fully
    '{1,0,0,1, 6,2,0,0,0, 6,1,0}   // R2 shrink after expansion
  };

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic strobe_idle;
    tick;
    dsleep = 0; stpclk = 0; irq = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 ways", ways, NUM_WAYS);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ways", ways, NUM_WAYS);
    chk("R1 mask", way_en, 8'hFF);
    chk("R1 flush", flush, 0);
    chk("R1 inv", inv, 0);
    chk("R7 empty", empty, 0);

    foreach (VECS[i]) begin
      dsleep = VECS[i].ent; stpclk = VECS[i].stp; irq = VECS[i].irq;
      peer_c4 = VECS[i].pc4; ratio = VECS[i].ratio; step = CNT_W'(VECS[i].step);
      hint = VECS[i].hint; block = VECS[i].blk; pcs = VECS[i].pcs;
      strobe_idle;
      chk($sformatf("R2 vec%0d ways", i), ways, VECS[i].ways);
      chk($sformatf("R2 vec%0d flush", i), flush, VECS[i].fl);
      chk($sformatf("R8 vec%0d inv", i), inv, VECS[i].iv);
      chk($sformatf("R10 vec%0d mask", i), way_en, (1 << VECS[i].ways) - 1);
      chk($sformatf("R7 vec%0d empty", i), empty, VECS[i].ways == 0);
      block = 0; hint = 0;
      tick;
    end

    // R4: residency expiry blocks shrink and schedules expansion (R9)
    limit = 16'd5; stpclk = 1; strobe_idle;
    chk("R8 no restore at six", ways, 6);
    chk("R8 no inv at six", inv, 0);
    repeat (10) tick;
    dsleep = 1; strobe_idle;
    chk("R4 expired no shrink", ways, 6);
    chk("R4 expired no flush", flush, 0);
    irq = 1; strobe_idle;
    chk("R9 expiry expands", ways, 8);
    chk("R9 expiry inv", inv, 1);
    limit = 16'd1000;

    // R5, R7, R6 on an empty cache
    hint = 2'b10; dsleep = 1; strobe_idle; hint = 0;
    chk("R5 full shrink", ways, 0);
    chk("R7 esleep ok", es_ok, 1);
    chk("R6 deep ok", dp_ok, 1);
    es_en = 0; #1;
    chk("R7 esleep needs enable", es_ok, 0);
    es_en = 1; block = 1; #1;
    chk("R6 esleep blocked", es_ok, 0);
    chk("R6 deep blocked", dp_ok, 0);
    block = 0;

    // R3: ratio equal to threshold blocks shrink
    stpclk = 1; strobe_idle;
    chk("R8 restore", ways, 2);
    ratio = 5'd10; dsleep = 1; strobe_idle;
    chk("R3 ratio at threshold", ways, 2);
    ratio = 5'd9; dsleep = 1; strobe_idle;
    chk("R3 ratio below threshold", ways, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule